// File: doc/BRIEF.md
# Mode-Dependent Barrel Shift Unit

This block performs the integer shift operations of a processor that can run with either 32-bit or 64-bit general registers. It covers left, logical right and arithmetic right shifts, each with the amount taken from a register or from an immediate field, and each in a full-width form and a word form that always works on the low 32 bits. The active register width is chosen from three status bits. In supervisor mode the supervisor width bit decides the width. Otherwise the user width bit decides it.

The active width changes how the unit behaves. It changes how many amount bits count, whether the source is cut down to its low half, and whether the result is sign-extended from bit 31. It also decides whether an operation is legal at all. Word forms do not exist in 32-bit mode. A full-width immediate shift whose amount has bit 5 set is also illegal there. An illegal operation raises a flag and returns a zero result.

The unit takes one operation per cycle. It registers its outputs, so a result appears one clock after the operation is presented.

Top module: `shf_unit`

## Requirements
- R1: The unit runs in 64-bit mode when `priv_sup`=1 and `sup_wide`=1, or when `priv_sup`=0 and `usr_wide`=1. In every other case it runs in 32-bit mode.
- R2: `op[1:0]` selects the shift kind: 0 is left, 1 is logical right, 2 is arithmetic right, and 3 is reserved. `op[2]`=1 takes the amount from `imm_amt`, and 0 takes it from `amt_reg`. `op[3]`=1 selects the word form. A reserved kind is always illegal.
- R3: In 64-bit mode a non-word shift uses all 6 amount bits on the full 64-bit operand. An arithmetic right shift fills with bit 63.
- R4: In 32-bit mode a non-word shift uses only the low 5 amount bits. It shifts the low 32 bits of the operand and sign-extends the 32-bit result from bit 31 into bits 63:32. A logical right shift fills with zeros. An arithmetic right shift fills with operand bit 31.
- R5: In 32-bit mode a non-word immediate shift with `imm_amt[5]`=1 is illegal.
- R6: In 64-bit mode a word-form shift uses the low 5 amount bits and the low 32 operand bits, and sign-extends the 32-bit result from bit 31. This holds for both amount sources.
- R7: A word-form shift in 32-bit mode is illegal.
- R8: When `illegal` is 1, `result` is zero.
- R9: `out_valid`, `result` and `illegal` are updated one clock after `in_valid` is sampled high. While `in_valid` is low, `out_valid` falls to 0 and `result` and `illegal` keep their values.
- R10: While `rst` is high, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Kind in [1:0], immediate select in [2], word form in [3] |
| operand | input | W (64) | Value to shift |
| amt_reg | input | AW (6) | Register-sourced shift amount (low bits of the second operand) |
| imm_amt | input | AW (6) | Immediate shift amount field |
| priv_sup | input | 1 | Supervisor privilege is active |
| sup_wide | input | 1 | Supervisor runs with 64-bit registers |
| usr_wide | input | 1 | User runs with 64-bit registers |
| out_valid | output | 1 | Result registered from the previous cycle |
| result | output | W (64) | Shift result |
| illegal | output | 1 | Operation is illegal in the current mode |

## Verification
A wrong width choice or a mis-masked amount shows up in the cycle right after the operation. It appears as a result whose upper half is not a copy of bit 31, or as bits that moved by 32 places too many or too few. A wrong legality decision shows up in that same registered cycle, as a flipped `illegal` flag together with a nonzero or unexpected result. The bench compares every registered result and flag against a separate model of the mode rules. It uses random operands and status bits, plus boundary amounts of 0, 31, 32 and 63.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SK_LEFT = 2'd0,
    SK_RLOG = 2'd1,
    SK_RARI = 2'd2,
    SK_RSVD = 2'd3
  } shf_kind_e;

endpackage

// File: rtl/shf_mode_sel.sv
module shf_mode_sel (
  input  logic priv_sup,
  input  logic sup_wide,
  input  logic usr_wide,
  output logic wide
);

  // The privilege level decides which width bit applies.
  always_comb begin
    wide = priv_sup ? sup_wide : usr_wide;
  end

endmodule

// File: rtl/shf_decode.sv
module shf_decode
  import shf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [3:0]    op,
  input  logic          wide,
  input  logic [AW-1:0] amt_reg,
  input  logic [AW-1:0] imm_amt,
  output shf_kind_e     kind,
  output logic          narrow,
  output logic [AW-1:0] amt,
  output logic          illegal
);

  logic          is_word;
  logic          is_imm;
  logic [AW-1:0] raw_amt;

  always_comb begin
    is_word = op[3];
    is_imm  = op[2];
    kind    = shf_kind_e'(op[1:0]);

    // Word forms and 32-bit mode both work on the low half.
    narrow  = is_word | ~wide;

    raw_amt = is_imm ? imm_amt : amt_reg;
    amt     = narrow ? {1'b0, raw_amt[AW-2:0]} : raw_amt;

    illegal = (kind == SK_RSVD)
            | (is_word & ~wide)
            | (is_imm & ~is_word & ~wide & imm_amt[AW-1]);
  end

endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  logic [AW-1:0] amt,
  input  shf_kind_e     kind,
  input  logic          narrow,
  input  logic          zero_out,
  output logic [W-1:0]  res
);

  localparam int HW = W / 2;

  logic [W-1:0] prep;
  logic         fill;
  logic         go_left;
  logic [W-1:0] prep_rev;
  logic [W-1:0] stage_in;
  logic [W-1:0] stg [AW+1];
  logic [W-1:0] tail_rev;
  logic [W-1:0] shifted;

  // Cut the source down to the active width. An arithmetic shift
  // takes its sign from the truncated word.
  always_comb begin
    if (narrow) begin
      if (kind == SK_RARI) prep = {{HW{src[HW-1]}}, src[HW-1:0]};
      else                 prep = {{HW{1'b0}}, src[HW-1:0]};
    end else begin
      prep = src;
    end
    fill    = (kind == SK_RARI) ? prep[W-1] : 1'b0;
    go_left = (kind == SK_LEFT);
  end

  // A left shift runs through the right-shift stages on a bit-reversed word.
  for (genvar b = 0; b < W; b++) begin : g_rev
    assign prep_rev[b] = prep[W-1-b];
    assign tail_rev[b] = stg[AW][W-1-b];
  end

  assign stage_in = go_left ? prep_rev : prep;
  assign stg[0]   = stage_in;

  // Stage i shifts right by 2**i when amount bit i is set.
  for (genvar i = 0; i < AW; i++) begin : g_stage
    localparam int SH = 1 << i;
    assign stg[i+1] = amt[i] ? {{SH{fill}}, stg[i][W-1:SH]} : stg[i];
  end

  assign shifted = go_left ? tail_rev : stg[AW];

  always_comb begin
    if (zero_out)    res = '0;
    else if (narrow) res = {{HW{shifted[HW-1]}}, shifted[HW-1:0]};
    else             res = shifted;
  end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [W-1:0]  operand,
  input  logic [AW-1:0] amt_reg,
  input  logic [AW-1:0] imm_amt,
  input  logic          priv_sup,
  input  logic          sup_wide,
  input  logic          usr_wide,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          illegal
);

  localparam int HW = W / 2;

  logic          wide;
  shf_kind_e     kind;
  logic          narrow;
  logic [AW-1:0] amt;
  logic          ill_c;
  logic [W-1:0]  res_c;

  shf_mode_sel u_mode (
    .priv_sup (priv_sup),
    .sup_wide (sup_wide),
    .usr_wide (usr_wide),
    .wide     (wide)
  );

  shf_decode #(.AW(AW)) u_dec (
    .op      (op),
    .wide    (wide),
    .amt_reg (amt_reg),
    .imm_amt (imm_amt),
    .kind    (kind),
    .narrow  (narrow),
    .amt     (amt),
    .illegal (ill_c)
  );

  shf_core #(.W(W), .AW(AW)) u_core (
    .src      (operand),
    .amt      (amt),
    .kind     (kind),
    .narrow   (narrow),
    .zero_out (ill_c),
    .res      (res_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_c;
        illegal <= ill_c;
      end
    end
  end

  // R8: an illegal operation never leaks a value.
  a_r8_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (result == '0));

  // R7: word forms are refused in 32-bit mode.
  a_r7_word_narrow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[3] && !wide) |=> illegal);

  // R5: an immediate amount of 32 or more is refused in 32-bit mode.
  a_r5_imm_hi_bit: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[2] && !op[3] && !wide && imm_amt[AW-1]) |=> illegal);

  // R2: the reserved kind is refused.
  a_r2_rsvd_kind: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[1:0] == 2'b11) |=> illegal);

  // R4 and R6: narrow results are sign-extended copies of bit HW-1.
  a_r4_narrow_sext: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow && !ill_c) |=> (result[W-1:HW] == {HW{result[HW-1]}}));

  // R9: idle cycles keep the last result and lower the valid flag.
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(illegal) && !out_valid));

endmodule

// File: tb/shf_unit_tb.sv
module shf_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [63:0] operand;
  logic [5:0]  amt_reg;
  logic [5:0]  imm_amt;
  logic        priv_sup, sup_wide, usr_wide;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  shf_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .operand(operand),
    .amt_reg(amt_reg), .imm_amt(imm_amt), .priv_sup(priv_sup),
    .sup_wide(sup_wide), .usr_wide(usr_wide), .out_valid(out_valid),
    .result(result), .illegal(illegal)
  );

  // Independent reference model: returns {illegal, result}.
  function automatic logic [64:0] model(input logic [3:0] o, input logic [63:0] x,
      input logic [5:0] ra, input logic [5:0] ia, input logic s, input logic sw,
      input logic uw);
    logic        w, ill;
    logic [5:0]  a;
    logic [63:0] r;
    logic [31:0] t;
    logic [31:0] lo;
    w   = s ? sw : uw;
    a   = o[2] ? ia : ra;
    ill = (o[1:0] == 2'd3) || (o[3] && !w) || (o[2] && !o[3] && !w && ia[5]);
    if (ill) return {1'b1, 64'd0};
    if (w && !o[3]) begin
      case (o[1:0])
        2'd0:    r = x << a;
        2'd1:    r = x >> a;
        default: r = $signed(x) >>> a;
      endcase
    end else begin
      lo = x[31:0];
      case (o[1:0])
        2'd0:    t = lo << a[4:0];
        2'd1:    t = lo >> a[4:0];
        default: t = $signed(lo) >>> a[4:0];
      endcase
      r = {{32{t[31]}}, t};
    end
    return {1'b0, r};
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic [5:0] ia,
      input logic s, input logic sw, input logic uw);
    logic w;
    w = s ? sw : uw;
    if (o[1:0] == 2'd3)          return "R2";
    if (o[3] && !w)              return "R7";
    if (o[2] && !o[3] && !w && ia[5]) return "R5";
    if (o[3])                    return "R6";
    if (w)                       return "R3";
    return "R4";
  endfunction

  task automatic check64(input string tg, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tg, got, exp);
    end
  endtask

  task automatic run(input string forced, input logic [3:0] o, input logic [63:0] x,
      input logic [5:0] ra, input logic [5:0] ia, input logic s, input logic sw,
      input logic uw);
    logic [64:0] e;
    string tg;
    e  = model(o, x, ra, ia, s, sw, uw);
    tg = (forced != "") ? forced : tag_of(o, ia, s, sw, uw);
    @(negedge clk);
    in_valid = 1'b1; op = o; operand = x; amt_reg = ra; imm_amt = ia;
    priv_sup = s; sup_wide = sw; usr_wide = uw;
    @(negedge clk);
    check64("R9", {63'd0, out_valid}, 64'd1);
    check64(tg, {63'd0, illegal}, {63'd0, e[64]});
    check64(e[64] ? "R8" : tg, result, e[63:0]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] held;
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; op = '0; operand = '0; amt_reg = '0; imm_amt = '0;
    priv_sup = 1'b0; sup_wide = 1'b0; usr_wide = 1'b0;
    repeat (3) @(negedge clk);
    // R10: cleared outputs during reset
    check64("R10", result, 64'd0);
    check64("R10", {62'd0, out_valid, illegal}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1: same operation, width picked by privilege and width bits
    run("R1", 4'b0010, 64'h0000_0001_8000_0000, 6'd4, 6'd0, 1'b1, 1'b1, 1'b0);
    run("R1", 4'b0010, 64'h0000_0001_8000_0000, 6'd4, 6'd0, 1'b0, 1'b1, 1'b0);
    run("R1", 4'b0000, 64'h0000_0000_0000_0001, 6'd40, 6'd0, 1'b0, 1'b0, 1'b1);
    run("R1", 4'b0000, 64'h0000_0000_0000_0001, 6'd40, 6'd0, 1'b1, 1'b0, 1'b1);

    // Directed corners
    run("R3", 4'b0010, 64'h8000_0000_0000_0000, 6'd63, 6'd0, 1'b1, 1'b1, 1'b0);
    run("R3", 4'b0100, 64'h0000_0000_0000_0001, 6'd0, 6'd63, 1'b1, 1'b1, 1'b0);
    run("R4", 4'b0010, 64'h0000_0000_8000_0000, 6'd63, 6'd0, 1'b0, 1'b0, 1'b0);
    run("R4", 4'b0001, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 6'd0, 1'b0, 1'b0, 1'b0);
    run("R4", 4'b0001, 64'hFFFF_FFFF_FFFF_FFFF, 6'd33, 6'd0, 1'b0, 1'b0, 1'b0);
    run("R4", 4'b0000, 64'hFFFF_FFFF_0000_0001, 6'd31, 6'd0, 1'b0, 1'b0, 1'b0);
    run("R4", 4'b0110, 64'h0000_0000_F000_0000, 6'd0, 6'd31, 1'b0, 1'b0, 1'b0);
    run("R5", 4'b0100, 64'h0000_0000_0000_0001, 6'd0, 6'd32, 1'b0, 1'b0, 1'b0);
    run("R6", 4'b1000, 64'h1234_5678_4000_0001, 6'd33, 6'd0, 1'b1, 1'b1, 1'b1);
    run("R6", 4'b1101, 64'hFFFF_FFFF_8000_0000, 6'd0, 6'd32, 1'b0, 1'b0, 1'b1);
    run("R7", 4'b1010, 64'hDEAD_BEEF_CAFE_F00D, 6'd3, 6'd0, 1'b0, 1'b1, 1'b0);
    run("R2", 4'b0011, 64'hDEAD_BEEF_CAFE_F00D, 6'd3, 6'd0, 1'b1, 1'b1, 1'b1);

    // R9: idle cycle holds result and drops valid
    run("", 4'b0001, 64'h0F0F_0000_1111_2222, 6'd8, 6'd0, 1'b1, 1'b1, 1'b0);
    held = result;
    @(negedge clk);
    in_valid = 1'b0; operand = 64'hAAAA_AAAA_AAAA_AAAA; op = 4'b0011;
    @(negedge clk);
    check64("R9", {63'd0, out_valid}, 64'd0);
    check64("R9", result, held);

    // Random mix
    for (int k = 0; k < 800; k++) begin
      logic [63:0] x;
      x = {$urandom(), $urandom()};
      run("", 4'($urandom()), x, 6'($urandom()), 6'($urandom()),
          1'($urandom()), 1'($urandom()), 1'($urandom()));
    end

    @(negedge clk);
    in_valid = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule